// File: doc/BRIEF.md
# Slot Mailbox Ring Controller

This block carries 32-bit slots between a host and a peer through two circular rings that sit behind a four-word register window. The host pushes slots toward the peer through a transmit window and pops slots that the peer produced through a receive window. A host control word holds the interrupt enable, interrupt status, a doorbell toward the peer, a ready flag, a reset request and a sticky overflow flag. It also reports the pointers of the outbound ring. A peer status word reports the inbound ring pointers, the peer's ready line and the reset request as the peer sees it. Both words carry the ring capacity in slots.

The peer side is a plain slot interface: a pop strobe with data returned on the next cycle, a push strobe with data, a ready line and a doorbell strobe toward the host. Each pointer is a free-running 8-bit counter. Software finds the occupancy as the write pointer minus the read pointer, taken modulo 256, and finds the free space as the capacity minus that occupancy.

Top module: `mbox_ring_ctrl`

## Requirements
- R1: After reset, both rings are empty with all pointers at 0, and the host word reads 0 in bits 23:0. The peer word bit 3 follows `peer_ready`, its other bits 23:0 read 0, and `bus_rdata`, `peer_rx_data`, `host_irq` and `peer_event` are 0.
- R2: A bus write at offset 0x0 to a ring that is not full stores one slot and advances the outbound write pointer (host word bits 23:16) by one. The read pointer sits in host word bits 15:8.
- R3: A write at offset 0x0 while the outbound ring holds DEPTH slots is discarded and sets the sticky overflow flag (host word bit 5). Writing 1 to that bit at offset 0x4 clears it.
- R4: `peer_rx_pop` returns the outbound slots in write order on `peer_rx_data` one cycle after the strobe. A pop on an empty ring returns 0 and leaves the pointers unchanged.
- R5: `peer_tx_push` stores slots in the inbound ring, and a full ring discards the push. A bus read at offset 0x8 pops them in order, and a read on an empty ring returns 0. Inbound pointers appear in the peer word at offset 0xC, read pointer in bits 15:8 and write pointer in bits 23:16.
- R6: Bits 31:24 of both status words read DEPTH, and writes cannot change them.
- R7: A `peer_doorbell` strobe sets interrupt status (host bit 1). Writing 1 to bit 1 clears it, and a doorbell in the same cycle wins. Host bit 0 is interrupt enable, and `host_irq` is high exactly while enable and status are both 1.
- R8: Writing 1 to host bit 2 drives `peer_event` high for exactly the next cycle. Bit 2 always reads 0.
- R9: Host bit 4 is the reset request and bit 3 is host ready. Writing the reset bit as 1 forces ready to 0. While the request is held, both rings are emptied by setting each read pointer equal to its write pointer, and pushes and pops have no effect. Peer word bit 4 mirrors the request.
- R10: The 8-bit pointers wrap from 255 to 0 while the slot order through the ring is kept for any DEPTH up to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset: 0x0 transmit window, 0x4 host word, 0x8 receive window, 0xC peer word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, otherwise 0 |
| host_irq | output | 1 | Interrupt to host (enable and status) |
| peer_event | output | 1 | One-cycle doorbell toward the peer |
| peer_ready | input | 1 | Peer ready flag, shown in peer word bit 3 |
| peer_doorbell | input | 1 | Peer strobe that sets host interrupt status |
| peer_rx_pop | input | 1 | Peer takes one outbound slot |
| peer_rx_data | output | 32 | Popped outbound slot, the cycle after the pop, otherwise 0 |
| peer_tx_push | input | 1 | Peer stores one inbound slot |
| peer_tx_data | input | 32 | Inbound slot data |

## Verification
Every result lands exactly one clock edge after its cause. Read data, popped peer data and the doorbell pulse all appear in the cycle after their strobe. Pointer movements, overflow and interrupt status become visible to a read issued in any later cycle. `host_irq` follows on the same edge that updates status or enable. The bench updates a queue-based model on the same rising edge as the design, drives stimulus and compares all four outputs on the falling edge, so every expected value lines up with the cycle in which the design produces it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SLOT_W = 32;
  localparam int PTR_W  = 8;

  localparam logic [3:0] OFS_TXWIN = 4'h0;
  localparam logic [3:0] OFS_HSTAT = 4'h4;
  localparam logic [3:0] OFS_RXWIN = 4'h8;
  localparam logic [3:0] OFS_PSTAT = 4'hC;

  localparam int B_IE  = 0;
  localparam int B_IS  = 1;
  localparam int B_IG  = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_OVF = 5;
  localparam int CTL_W = 6;

  typedef struct packed {
    logic ovf;
    logic rst_req;
    logic rdy;
    logic irq_st;
    logic irq_en;
  } host_ctl_t;
endpackage

// File: rtl/mbox_slot_ring.sv
module mbox_slot_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int PW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] wptr,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] ridx, widx;
  logic [PW-1:0] level;
  logic          do_push, do_pop;

  function automatic logic [IW-1:0] idx_next(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign level   = wptr - rptr;
  assign full    = (level == PW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr <= '0;
      wptr <= '0;
      ridx <= '0;
      widx <= '0;
    end else if (flush) begin
      rptr <= wptr;
      ridx <= widx;
    end else begin
      if (do_push) begin
        wptr <= wptr + 1'b1;
        widx <= idx_next(widx);
      end
      if (do_pop) begin
        rptr <= rptr + 1'b1;
        ridx <= idx_next(ridx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[widx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[ridx];
    else             pop_data <= '0;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= PW'(DEPTH));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
  p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (pop_data == '0));
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !flush) |=> (wptr == $past(wptr) + 1'b1));
endmodule

// File: rtl/mbox_host_csr.sv
module mbox_host_csr
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             doorbell,
  input  logic             ovf_set,
  output host_ctl_t        ctl,
  output logic             event_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      event_out <= 1'b0;
    end else begin
      event_out <= we & wdata[B_IG];
      if (we) begin
        ctl.irq_en  <= wdata[B_IE];
        ctl.rst_req <= wdata[B_RST];
        ctl.rdy     <= wdata[B_RDY] & ~wdata[B_RST];
      end
      if (doorbell)                 ctl.irq_st <= 1'b1;
      else if (we && wdata[B_IS])   ctl.irq_st <= 1'b0;
      if (ovf_set)                  ctl.ovf <= 1'b1;
      else if (we && wdata[B_OVF])  ctl.ovf <= 1'b0;
    end
  end

  p_ready_low_in_reset_r9: assert property (@(posedge clk) disable iff (rst)
    ctl.rst_req |-> !ctl.rdy);
  p_event_from_write_r8: assert property (@(posedge clk) disable iff (rst)
    event_out |-> $past(we && wdata[B_IG]));
  p_status_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[B_IS] && !doorbell) |=> !ctl.irq_st);
  p_doorbell_sets_r7: assert property (@(posedge clk) disable iff (rst)
    doorbell |=> ctl.irq_st);
endmodule

// File: rtl/mbox_ring_ctrl.sv
module mbox_ring_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [SLOT_W-1:0] bus_wdata,
  output logic [SLOT_W-1:0] bus_rdata,
  output logic              host_irq,
  output logic              peer_event,
  input  logic              peer_ready,
  input  logic              peer_doorbell,
  input  logic              peer_rx_pop,
  output logic [SLOT_W-1:0] peer_rx_data,
  input  logic              peer_tx_push,
  input  logic [SLOT_W-1:0] peer_tx_data
);
  localparam int NDIR = 2;
  localparam logic [PTR_W-1:0] DEPTH_F = PTR_W'(DEPTH);

  host_ctl_t         ctl;
  logic [NDIR-1:0]   r_push, r_pop, r_full, r_empty;
  logic [SLOT_W-1:0] r_wdata [NDIR];
  logic [SLOT_W-1:0] r_rdata [NDIR];
  logic [PTR_W-1:0]  r_rp [NDIR];
  logic [PTR_W-1:0]  r_wp [NDIR];
  logic              host_tx_wr, host_rx_rd, csr_we;
  logic [SLOT_W-1:0] host_word, peer_word, stat_q;
  logic              rd_q, rxwin_q;

  assign host_tx_wr = bus_wr && (bus_addr == OFS_TXWIN);
  assign csr_we     = bus_wr && (bus_addr == OFS_HSTAT);
  assign host_rx_rd = bus_rd && (bus_addr == OFS_RXWIN);

  assign r_push[0]  = host_tx_wr;
  assign r_wdata[0] = bus_wdata;
  assign r_pop[0]   = peer_rx_pop;
  assign r_push[1]  = peer_tx_push;
  assign r_wdata[1] = peer_tx_data;
  assign r_pop[1]   = host_rx_rd;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    mbox_slot_ring #(.DEPTH(DEPTH), .DW(SLOT_W), .PW(PTR_W)) u_ring (
      .clk      (clk),
      .rst      (rst),
      .flush    (ctl.rst_req),
      .push     (r_push[d]),
      .push_data(r_wdata[d]),
      .pop      (r_pop[d]),
      .pop_data (r_rdata[d]),
      .rptr     (r_rp[d]),
      .wptr     (r_wp[d]),
      .full     (r_full[d]),
      .empty    (r_empty[d])
    );
  end

  mbox_host_csr u_csr (
    .clk      (clk),
    .rst      (rst),
    .we       (csr_we),
    .wdata    (bus_wdata[CTL_W-1:0]),
    .doorbell (peer_doorbell),
    .ovf_set  (host_tx_wr && r_full[0] && !ctl.rst_req),
    .ctl      (ctl),
    .event_out(peer_event)
  );

  assign host_word = {DEPTH_F, r_wp[0], r_rp[0], 2'b00, ctl.ovf, ctl.rst_req,
                      ctl.rdy, 1'b0, ctl.irq_st, ctl.irq_en};
  assign peer_word = {DEPTH_F, r_wp[1], r_rp[1], 3'b000, ctl.rst_req,
                      peer_ready, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      rxwin_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      rd_q    <= bus_rd;
      rxwin_q <= host_rx_rd;
      case (bus_addr)
        OFS_HSTAT: stat_q <= host_word;
        OFS_PSTAT: stat_q <= peer_word;
        default:   stat_q <= '0;
      endcase
    end
  end

  assign bus_rdata    = !rd_q ? '0 : (rxwin_q ? r_rdata[1] : stat_q);
  assign peer_rx_data = r_rdata[0];
  assign host_irq     = ctl.irq_en & ctl.irq_st;

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    (csr_we && !bus_wdata[B_IE]) |=> !host_irq);
  p_ovf_on_full_write_r3: assert property (@(posedge clk) disable iff (rst)
    (host_tx_wr && r_full[0] && !ctl.rst_req) |=> ctl.ovf);
  p_rx_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rx_rd && r_empty[1]) |=> (bus_rdata == '0));
endmodule

// File: tb/test_mbox_ring_ctrl.sv
`timescale 1ns/1ps
module test_mbox_ring_ctrl;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        host_irq, peer_event;
  logic        peer_ready = 0, peer_doorbell = 0, peer_rx_pop = 0, peer_tx_push = 0;
  logic [31:0] peer_rx_data;
  logic [31:0] peer_tx_data = 0;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  always #2.5 clk = ~clk;

  mbox_ring_ctrl #(.DEPTH(DEPTH)) i_mbox_ring_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq),
    .peer_event(peer_event), .peer_ready(peer_ready), .peer_doorbell(peer_doorbell),
    .peer_rx_pop(peer_rx_pop), .peer_rx_data(peer_rx_data),
    .peer_tx_push(peer_tx_push), .peer_tx_data(peer_tx_data)
  );

  // Behavioural reference model
  logic [31:0] q_out[$];
  logic [31:0] q_in[$];
  logic [7:0]  m_owp, m_orp, m_iwp, m_irp;
  logic        m_ie, m_is, m_rdy, m_rst, m_ovf;
  logic [31:0] e_rdata, e_prx;
  logic        e_evt;

  always @(posedge clk) begin
    if (rst) begin
      q_out.delete(); q_in.delete();
      m_owp = 0; m_orp = 0; m_iwp = 0; m_irp = 0;
      m_ie = 0; m_is = 0; m_rdy = 0; m_rst = 0; m_ovf = 0;
      e_rdata = 0; e_prx = 0; e_evt = 0;
    end else begin
      int o_pre, i_pre;
      bit flush;
      o_pre = q_out.size();
      i_pre = q_in.size();
      flush = m_rst;
      e_rdata = 0;
      e_prx = 0;
      if (bus_rd) begin
        if (bus_addr == 4'h4)
          e_rdata = {8'(DEPTH), m_owp, m_orp, 2'b00, m_ovf, m_rst, m_rdy, 1'b0, m_is, m_ie};
        else if (bus_addr == 4'hC)
          e_rdata = {8'(DEPTH), m_iwp, m_irp, 3'b000, m_rst, peer_ready, 3'b000};
        else if (bus_addr == 4'h8 && !flush && i_pre > 0) begin
          e_rdata = q_in.pop_front(); m_irp++;
        end
      end
      if (peer_rx_pop && !flush && o_pre > 0) begin
        e_prx = q_out.pop_front(); m_orp++;
      end
      if (bus_wr && bus_addr == 4'h0 && !flush) begin
        if (o_pre < DEPTH) begin q_out.push_back(bus_wdata); m_owp++; end
        else m_ovf = 1;
      end
      if (peer_tx_push && !flush && i_pre < DEPTH) begin
        q_in.push_back(peer_tx_data); m_iwp++;
      end
      if (flush) begin
        q_out.delete(); q_in.delete(); m_orp = m_owp; m_irp = m_iwp;
      end
      e_evt = bus_wr && bus_addr == 4'h4 && bus_wdata[2];
      if (bus_wr && bus_addr == 4'h4) begin
        m_ie = bus_wdata[0];
        if (bus_wdata[1]) m_is = 0;
        if (bus_wdata[5] && !(bus_wr && bus_addr == 4'h0)) m_ovf = 0;
        m_rdy = bus_wdata[3] & ~bus_wdata[4];
        m_rst = bus_wdata[4];
      end
      if (peer_doorbell) m_is = 1;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("bus_rdata", bus_rdata, e_rdata);
      check("peer_rx_data", peer_rx_data, e_prx);
      check("host_irq", 32'(host_irq), 32'(m_ie & m_is));
      check("peer_event", 32'(peer_event), 32'(e_evt));
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic bus_read(input logic [3:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic p_pop();
    @(negedge clk); peer_rx_pop = 1;
    @(negedge clk); peer_rx_pop = 0;
  endtask
  task automatic p_push(input logic [31:0] d);
    @(negedge clk); peer_tx_push = 1; peer_tx_data = d;
    @(negedge clk); peer_tx_push = 0;
  endtask
  task automatic p_bell();
    @(negedge clk); peer_doorbell = 1;
    @(negedge clk); peer_doorbell = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: state straight after reset
    cur_req = "R1";
    bus_read(4'h4); bus_read(4'hC); bus_read(4'h8); p_pop();
    // R6: depth field cannot be written
    cur_req = "R6";
    bus_write(4'h4, 32'hFF00_0000); bus_read(4'h4); bus_read(4'hC);
    // R2: pushes through the transmit window advance the write pointer
    cur_req = "R2";
    bus_write(4'h0, 32'hA000_0001); bus_write(4'h0, 32'hA000_0002);
    bus_write(4'h0, 32'hA000_0003); bus_read(4'h4);
    // R4: peer pops in order, then one empty pop returns zero
    cur_req = "R4";
    repeat (4) p_pop();
    bus_read(4'h4);
    // R3: fill, overflow, clear
    cur_req = "R3";
    for (int i = 0; i < DEPTH + 1; i++) bus_write(4'h0, 32'hB000_0000 + 32'(i));
    bus_read(4'h4);
    bus_write(4'h4, 32'h0000_0020); bus_read(4'h4);
    cur_req = "R4";
    repeat (DEPTH + 1) p_pop();
    // R5: peer pushes, host pops through the receive window
    cur_req = "R5";
    for (int i = 0; i < 5; i++) p_push(32'hC000_0010 + 32'(i));
    bus_read(4'hC);
    repeat (6) bus_read(4'h8);
    for (int i = 0; i < DEPTH + 2; i++) p_push(32'hD000_0000 + 32'(i));
    bus_read(4'hC);
    repeat (DEPTH + 1) bus_read(4'h8);
    // R7: doorbell, enable, clear
    cur_req = "R7";
    p_bell(); bus_read(4'h4);
    bus_write(4'h4, 32'h1); bus_read(4'h4);
    bus_write(4'h4, 32'h3); bus_read(4'h4);
    @(negedge clk); peer_doorbell = 1; bus_wr = 1; bus_addr = 4'h4; bus_wdata = 32'h3;
    @(negedge clk); peer_doorbell = 0; bus_wr = 0;
    bus_write(4'h4, 32'h0);
    // R8: doorbell toward the peer
    cur_req = "R8";
    bus_write(4'h4, 32'h4); bus_read(4'h4);
    // R9: reset request and ready handshake
    cur_req = "R9";
    bus_write(4'h4, 32'h8);
    bus_write(4'h0, 32'hE000_0001); bus_write(4'h0, 32'hE000_0002);
    p_push(32'hE100_0001);
    bus_write(4'h4, 32'h18); bus_read(4'h4); bus_read(4'hC);
    bus_write(4'h0, 32'hE000_0003); p_push(32'hE100_0002);
    p_pop(); bus_read(4'h8); bus_read(4'h4); bus_read(4'hC);
    peer_ready = 1; bus_read(4'hC);
    bus_write(4'h4, 32'h8); bus_read(4'h4);
    bus_write(4'h0, 32'hE000_0004); p_pop();
    // R10: pointer wrap past 255
    cur_req = "R10";
    for (int i = 0; i < 270; i++) begin
      bus_write(4'h0, 32'hF000_0000 + 32'(i));
      p_pop();
    end
    bus_read(4'h4);
    @(negedge clk); bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'hF1F1_0001; peer_rx_pop = 1;
    @(negedge clk); bus_wr = 0; peer_rx_pop = 0;
    p_pop(); bus_read(4'h4);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule